// File: doc/BRIEF.md
# Chip-Addressed Serial Slave Front End

This block is the receive and transmit front end of a serial peripheral slave. Up to four devices share one active-low select line. Each frame opens with a two-bit chip address, and only the device whose strapped address matches takes part in the frame. The serial clock, select and data input are synchronised into a faster system clock and edge-detected there. The data input is captured on falling serial clock edges. A response byte, loaded when select falls, is driven out on rising serial clock edges.

The output enable stays low through the addressing phase. It stays low for the whole frame if the address does not match. A frame carries exactly eight bits: two address bits followed by a six-bit instruction. The instruction goes to the register layer as a one-cycle strobe in the system clock domain, and only when select returns high after a frame that matched and held exactly eight bits. Any other frame is discarded.

Top module: `addr_spi_slave`

## Requirements
- R1: While `rst_n` is low, `miso_oe` and `cmd_valid` are 0. This holds even if reset arrives in the middle of a frame, and the interrupted frame never produces a command.
- R2: When `sel_n` is high, `miso_oe` is 0. It drops without waiting for the system clock.
- R3: While `sel_n` is low, `mosi` is sampled on each falling `sclk` edge, most significant bit first. The last six bits of an eight-bit frame appear on `cmd_data` with the first received instruction bit at bit 5. `cmd_data` changes only in the cycle `cmd_valid` is 1.
- R4: The first two bits of a frame form the chip address, with the first bit as address bit 1. They are compared against `chip_addr`.
- R5: On an address mismatch, `miso_oe` stays 0 for the entire frame and no command is produced.
- R6: On an address match, `miso_oe` is 0 through the first two bit periods. It becomes 1 from the third rising `sclk` edge and stays 1 while `sel_n` is low.
- R7: After a match, the k-th rising `sclk` edge (k of 3 or more) drives `status_in[10-k]` on `miso`. `status_in` is captured when `sel_n` falls, and later changes to it within the frame have no effect.
- R8: `cmd_valid` is a one-cycle pulse that follows the rising edge of `sel_n`. It never occurs while `sel_n` is low.
- R9: A frame with more or fewer than eight falling `sclk` edges produces no command.
- R10: `sclk` and `mosi` activity while `sel_n` is high is ignored. The next frame decodes as if it were the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_addr | input | 2 | Strapped device address |
| sel_n | input | 1 | Active-low frame select from the master |
| sclk | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data from the master |
| status_in | input | 8 | Parallel response byte, captured when select falls |
| miso | output | 1 | Serial response data |
| miso_oe | output | 1 | Output enable for the `miso` pad; 0 means high impedance |
| cmd_valid | output | 1 | One-cycle strobe for a committed instruction |
| cmd_data | output | 6 | Committed instruction |

## Verification
Matching frames with different instruction and status patterns show bit order and alignment on both directions. This includes all-ones and all-zeros values, which expose stuck or shifted bits. A frame addressed to another device, and the same address after the strap changes, show that the comparison uses the strap and not a constant. Frames of five and nine bits show that the commit depends on the exact count. Stray clocks with select high, and a reset in the middle of a frame, show that the counter and shift state restart cleanly for the next frame.

// File: rtl/spi_addr_pkg.sv
package spi_addr_pkg;
    localparam int ADDR_W   = 2;
    localparam int INSTR_W  = 6;
    localparam int FRAME_W  = ADDR_W + INSTR_W;
    localparam int STATUS_W = 8;
    localparam int SYNC_STAGES = 2;

    // indices of the synchronised input vector
    localparam int IDX_SEL  = 0;
    localparam int IDX_SCLK = 1;
    localparam int IDX_MOSI = 2;
    localparam int N_IN     = 3;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
    parameter int          N       = 3,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_ch
        typedef struct packed {
            logic [STAGES-1:0] chain;
            logic              prev;
        } sync_t;

        sync_t st_d, st_q;

        always_comb begin
            st_d       = st_q;
            st_d.chain = {st_q.chain[STAGES-2:0], async_in[i]};
            st_d.prev  = st_q.chain[STAGES-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q.chain <= {STAGES{RST_VAL[i]}};
                st_q.prev  <= RST_VAL[i];
            end else begin
                st_q <= st_d;
            end
        end

        assign level[i] = st_q.chain[STAGES-1];
        assign rise[i]  = st_q.chain[STAGES-1] & ~st_q.prev;
        assign fall[i]  = ~st_q.chain[STAGES-1] & st_q.prev;
    end
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import spi_addr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int IW = INSTR_W,
    localparam int FW = AW + IW,
    localparam int CW = $clog2(FW + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] chip_addr,
    input  logic          sel_idle,
    input  logic          sel_rise,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic          mosi_lvl,
    output logic          drive_bit,
    output logic          oe,
    output logic          cmd_vld,
    output logic [IW-1:0] cmd
);
    localparam logic [CW-1:0] CNT_FULL = CW'(FW);
    localparam logic [CW-1:0] CNT_SAT  = CW'(FW + 1);
    localparam logic [CW-1:0] CNT_ADDR = CW'(AW);

    typedef struct packed {
        logic [CW-1:0] bit_cnt;
        logic [FW-1:0] shreg;
        logic          addr_ok;
        logic          oe;
        logic          cmd_vld;
        logic [IW-1:0] cmd;
    } frame_t;

    frame_t f_d, f_q;
    logic [AW-1:0] addr_now;

    assign addr_now = {f_q.shreg[AW-2:0], mosi_lvl};

    always_comb begin
        f_d         = f_q;
        f_d.cmd_vld = 1'b0;
        if (sel_idle) begin
            if (sel_rise && f_q.addr_ok && (f_q.bit_cnt == CNT_FULL)) begin
                f_d.cmd_vld = 1'b1;
                f_d.cmd     = f_q.shreg[IW-1:0];
            end
            f_d.bit_cnt = '0;
            f_d.addr_ok = 1'b0;
            f_d.oe      = 1'b0;
        end else begin
            if (sclk_fall) begin
                f_d.shreg = {f_q.shreg[FW-2:0], mosi_lvl};
                if (f_q.bit_cnt != CNT_SAT)
                    f_d.bit_cnt = f_q.bit_cnt + 1'b1;
                if (f_q.bit_cnt == CNT_ADDR - 1'b1)
                    f_d.addr_ok = (addr_now == chip_addr);
            end
            if (sclk_rise && f_q.addr_ok)
                f_d.oe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign drive_bit = sclk_rise & f_q.addr_ok & ~sel_idle;
    assign oe        = f_q.oe;
    assign cmd_vld   = f_q.cmd_vld;
    assign cmd       = f_q.cmd;

    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cmd_vld |=> !f_q.cmd_vld); // R8
    AST_CMD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.cmd_vld |-> sel_idle); // R8
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !f_q.cmd_vld |-> $stable(f_q.cmd)); // R3
    AST_OE_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.oe |-> (f_q.bit_cnt >= CNT_ADDR)); // R6
    AST_NO_OE_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_idle && f_q.bit_cnt >= CNT_ADDR && !f_q.addr_ok) |-> !f_q.oe); // R5
    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        sel_idle |=> (f_q.bit_cnt == '0 && !f_q.oe)); // R10
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          shift,
    input  logic          sel_idle,
    input  logic [SW-1:0] status,
    output logic          bit_out
);
    typedef struct packed {
        logic [SW-1:0] sr;
        logic          bo;
    } tx_t;

    tx_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (sel_idle) begin
            t_d.bo = 1'b0;
        end else if (load) begin
            t_d.sr = status;
            t_d.bo = 1'b0;
        end else if (shift) begin
            t_d.bo = t_q.sr[SW-1];
            t_d.sr = {t_q.sr[SW-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign bit_out = t_q.bo;

    AST_TX_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_idle |=> !t_q.bo); // R2
endmodule

// File: rtl/addr_spi_slave.sv
module addr_spi_slave
    import spi_addr_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int IW = INSTR_W,
    parameter int SW = STATUS_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] chip_addr,
    input  logic          sel_n,
    input  logic          sclk,
    input  logic          mosi,
    input  logic [SW-1:0] status_in,
    output logic          miso,
    output logic          miso_oe,
    output logic          cmd_valid,
    output logic [IW-1:0] cmd_data
);
    localparam logic [N_IN-1:0] SYNC_RST = N_IN'(1) << IDX_SEL;

    logic [N_IN-1:0] lvl, rise, fall;
    logic            drive_bit, oe_q, tx_bit;

    spi_edge_sync #(.N(N_IN), .STAGES(STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({mosi, sclk, sel_n}),
        .level    (lvl),
        .rise     (rise),
        .fall     (fall)
    );

    spi_frame_ctrl #(.AW(AW), .IW(IW)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .chip_addr (chip_addr),
        .sel_idle  (lvl[IDX_SEL]),
        .sel_rise  (rise[IDX_SEL]),
        .sclk_rise (rise[IDX_SCLK]),
        .sclk_fall (fall[IDX_SCLK]),
        .mosi_lvl  (lvl[IDX_MOSI]),
        .drive_bit (drive_bit),
        .oe        (oe_q),
        .cmd_vld   (cmd_valid),
        .cmd       (cmd_data)
    );

    spi_tx_shift #(.SW(SW)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fall[IDX_SEL]),
        .shift    (drive_bit),
        .sel_idle (lvl[IDX_SEL]),
        .status   (status_in),
        .bit_out  (tx_bit)
    );

    // raw select gates the enable so the pad releases at once
    assign miso_oe = oe_q & ~sel_n;
    assign miso    = tx_bit & miso_oe;
endmodule

// File: tb/sim_addr_spi_slave.sv
module sim_addr_spi_slave;
    localparam int H = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] chip_addr = 2'b10;
    logic       sel_n = 1'b1;
    logic       sclk = 1'b0;
    logic       mosi = 1'b0;
    logic [7:0] status_in = 8'h00;
    logic       miso, miso_oe, cmd_valid;
    logic [5:0] cmd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [5:0] exp_q[$];

    always #2.5 clk = ~clk;

    addr_spi_slave u0 (
        .clk(clk), .rst_n(rst_n), .chip_addr(chip_addr), .sel_n(sel_n),
        .sclk(sclk), .mosi(mosi), .status_in(status_in), .miso(miso),
        .miso_oe(miso_oe), .cmd_valid(cmd_valid), .cmd_data(cmd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // monitor: every commit strobe must match the oldest expected item
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            if (exp_q.size() == 0)
                chk(1'b0, "R8", "unexpected cmd_valid", {26'd0, cmd_data}, 32'd0);
            else begin
                logic [5:0] e;
                e = exp_q.pop_front();
                chk(cmd_data == e, "R3", "cmd_data", {26'd0, cmd_data}, {26'd0, e});
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_frame(input logic [1:0] a, input logic [5:0] ins, input int nb,
                             input logic [7:0] st, input bit match);
        logic [7:0] fb;
        fb = {a, ins};
        status_in = st;
        wait_n(2);
        sel_n = 1'b0;
        wait_n(10);
        status_in = ~st;             // R7: late change must be ignored
        for (int k = 1; k <= nb; k++) begin
            sclk = 1'b1;
            mosi = (k <= 8) ? fb[8-k] : 1'b0;
            wait_n(H);
            if (k >= 3 && match) begin
                chk(miso_oe == 1'b1, "R6", "oe after address", {31'd0, miso_oe}, 32'd1);
                chk(miso == st[10-k], "R7", "miso bit", {31'd0, miso}, {31'd0, st[10-k]});
            end else if (k >= 3) begin
                chk(miso_oe == 1'b0, "R5", "oe on mismatch", {31'd0, miso_oe}, 32'd0);
            end else begin
                chk(miso_oe == 1'b0, "R6", "oe in address phase", {31'd0, miso_oe}, 32'd0);
            end
            sclk = 1'b0;
            wait_n(H);
        end
        if (nb == 8 && match) exp_q.push_back(ins);
        chk(exp_q.size() == ((nb == 8 && match) ? 1 : 0), "R8", "no commit before select rise",
            exp_q.size(), (nb == 8 && match) ? 1 : 0);
        sel_n = 1'b1;
        #1;
        chk(miso_oe == 1'b0, "R2", "oe with select high", {31'd0, miso_oe}, 32'd0);
        wait_n(20);
        chk(exp_q.size() == 0, (nb != 8) ? "R9" : (match ? "R8" : "R5"),
            "pending commits", exp_q.size(), 0);
    endtask

    initial begin
        #1000000;
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        wait_n(3);
        chk(miso_oe == 1'b0 && cmd_valid == 1'b0, "R1", "reset outputs",
            {30'd0, miso_oe, cmd_valid}, 32'd0);
        rst_n = 1'b1;
        wait_n(5);

        run_frame(2'b10, 6'h2D, 8, 8'hA5, 1'b1);   // R3 R4 R6 R7
        run_frame(2'b10, 6'h12, 8, 8'h3C, 1'b1);
        run_frame(2'b01, 6'h15, 8, 8'hFF, 1'b0);   // R5 mismatch
        run_frame(2'b10, 6'h0F, 5, 8'h81, 1'b1);   // R9 short
        run_frame(2'b10, 6'h0F, 9, 8'h81, 1'b1);   // R9 long

        // R10: stray clocks with select high
        mosi = 1'b1;
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b1; wait_n(H);
            sclk = 1'b0; wait_n(H);
        end
        run_frame(2'b10, 6'h21, 8, 8'h5A, 1'b1);

        // R4: strap change moves the matching address
        chip_addr = 2'b01;
        wait_n(5);
        run_frame(2'b01, 6'h3F, 8, 8'hFF, 1'b1);
        run_frame(2'b10, 6'h3F, 8, 8'hFF, 1'b0);
        chip_addr = 2'b10;
        wait_n(5);

        // R1: reset inside a matching frame
        sel_n = 1'b0;
        wait_n(10);
        for (int k = 1; k <= 4; k++) begin
            sclk = 1'b1; mosi = (k == 1); wait_n(H);
            sclk = 1'b0; wait_n(H);
        end
        rst_n = 1'b0;
        wait_n(2);
        chk(miso_oe == 1'b0 && cmd_valid == 1'b0, "R1", "mid-frame reset",
            {30'd0, miso_oe, cmd_valid}, 32'd0);
        rst_n = 1'b1;
        wait_n(5);
        sel_n = 1'b1;
        wait_n(20);
        chk(exp_q.size() == 0, "R1", "no commit after reset", exp_q.size(), 0);

        run_frame(2'b10, 6'h00, 8, 8'h00, 1'b1);   // R10 fresh after abort
        run_frame(2'b10, 6'h3F, 8, 8'hFF, 1'b1);

        wait_n(10);
        finish_run();
    end
endmodule